// File: doc/BRIEF.md
# Pin Bank with Atomic Set, Clear and Toggle Aliases

This block is a memory-mapped general-purpose pin controller that sits behind a Wishbone slave port. It keeps two registers: a direction register, whose bits drive active-low per-pin output enables for external tri-state pads, and an output-level register, whose bits drive the pad output values. It also brings the external pin levels in through a two-flop synchroniser so that software can read them.

Each of the two registers can be written through four word addresses. The plain address replaces the register. The set, clear and toggle addresses change only the bits written as 1 and leave all other bits alone. Several bus masters can therefore each own a few pins and change them without a read-modify-write sequence. Byte-select lines limit every update to the bytes that are selected. Every access completes with a single-cycle acknowledge.

Top module: `pin_bank_top`

## Requirements
- R1: While reset is high, and after it is released, the direction register is all 1s (every `pad_oe_n` bit high, so every pin is an input), the output register is all 0s and `wb_ack_o` is low.
- R2: An access presented with `wb_cyc_i` and `wb_stb_i` high while `wb_ack_o` is low is acknowledged on the next clock edge, and `wb_ack_o` stays high for exactly one cycle.
- R3: A write to byte offset 0x00 (direction) or 0x10 (output) replaces the selected bytes of that register with the write data.
- R4: A write to offset 0x04 (direction) or 0x14 (output) ORs the write data into the selected bytes of the register.
- R5: A write to offset 0x08 (direction) or 0x18 (output) clears every selected bit that is 1 in the write data and leaves the others unchanged.
- R6: A write to offset 0x0C (direction) or 0x1C (output) inverts every selected bit that is 1 in the write data and leaves the others unchanged.
- R7: Bit n of a register can change only when `wb_sel_i[n/8]` is high during the write.
- R8: A read of any of the four direction offsets (0x00 to 0x0C) returns the direction register, and a read of any of the four output offsets (0x10 to 0x1C) returns the output register, zero-extended to the bus width.
- R9: A read of offset 0x20 returns the pin levels after two synchroniser flops. A level change made in the same cycle as the read request is not visible. A level held for at least two clock edges before the acknowledging edge is visible.
- R10: A write to offset 0x20 or to any offset above 0x20 changes no register, and a read of any offset above 0x20 returns 0.
- R11: `pad_oe_n` always equals the direction register and `pad_out` always equals the output register.
- R12: Toggling a field whose bits are all 1 leaves it all 0. Setting the bits of a field one at a time produces the same register value as one plain write of the whole field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 for a write, 0 for a read |
| wb_adr_i | input | AW | Byte address; bits [AW-1:2] select the word |
| wb_dat_i | input | DW | Write data |
| wb_sel_i | input | DW/8 | Byte selects for writes |
| wb_dat_o | output | DW | Registered read data |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| pad_in | input | NPINS | Asynchronous pin levels |
| pad_out | output | NPINS | Output level for each pin |
| pad_oe_n | output | NPINS | Active-low output enable for each pin (0 drives) |

## Verification
The assertions assume that a master keeps `wb_adr_i`, `wb_we_i`, `wb_dat_i` and `wb_sel_i` steady while its strobe is waiting for an acknowledge. They also assume that it drops the strobe after the acknowledge instead of starting the next access in the same cycle. The bench keeps to this by driving every access from one task. That task raises the strobe on a falling edge, holds all fields for one cycle, and returns the bus to idle in the cycle of the acknowledge. The pin inputs are changed only on falling edges, so the synchroniser never samples a level while it is changing.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  // Low two bits of the word index select how a write is applied.
  typedef enum logic [1:0] {
    ALIAS_WRITE  = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLEAR  = 2'd2,
    ALIAS_TOGGLE = 2'd3
  } alias_op_e;

  // Upper bits of the word index select the target.
  localparam int unsigned GRP_DIR  = 0;
  localparam int unsigned GRP_OUT  = 1;
  localparam int unsigned WORD_PIN = 8;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/alias_reg.sv
module alias_reg
  import pin_bank_pkg::*;
#(
  parameter int unsigned    W       = 32,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  alias_op_e    op,
  input  logic [W-1:0] data,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);

  logic [W-1:0] hit;
  logic [W-1:0] nxt;

  assign hit = data & mask;

  always_comb begin
    unique case (op)
      ALIAS_WRITE:  nxt = (q & ~mask) | hit;
      ALIAS_SET:    nxt = q | hit;
      ALIAS_CLEAR:  nxt = q & ~hit;
      ALIAS_TOGGLE: nxt = q ^ hit;
      default:      nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= nxt;
  end

endmodule

// File: rtl/pin_bank_top.sv
module pin_bank_top
  import pin_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [AW-1:0]     wb_adr_i,
  input  logic [DW-1:0]     wb_dat_i,
  input  logic [DW/8-1:0]   wb_sel_i,
  output logic [DW-1:0]     wb_dat_o,
  output logic              wb_ack_o,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe_n
);

  localparam int unsigned IW = AW - 2;

  logic             accept;
  logic [IW-1:0]    widx;
  alias_op_e        op;
  logic             dir_hit, out_hit, pin_hit;
  logic [NPINS-1:0] bmask;
  logic [NPINS-1:0] wdata;
  logic [NPINS-1:0] pin_sync_q;
  logic [DW-1:0]    rd_val;

  assign accept  = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign widx    = wb_adr_i[AW-1:2];
  assign op      = alias_op_e'(widx[1:0]);
  assign dir_hit = (widx >> 2) == IW'(GRP_DIR);
  assign out_hit = (widx >> 2) == IW'(GRP_OUT);
  assign pin_hit = widx == IW'(WORD_PIN);
  assign wdata   = wb_dat_i[NPINS-1:0];

  generate
    for (genvar b = 0; b < NPINS; b++) begin : g_mask
      assign bmask[b] = wb_sel_i[b/8];
    end
  endgenerate

  alias_reg #(.W(NPINS), .RST_VAL({NPINS{1'b1}})) u_dir (
    .clk(clk), .rst(rst), .wr_en(accept & wb_we_i & dir_hit),
    .op(op), .data(wdata), .mask(bmask), .q(pad_oe_n)
  );

  alias_reg #(.W(NPINS), .RST_VAL('0)) u_out (
    .clk(clk), .rst(rst), .wr_en(accept & wb_we_i & out_hit),
    .op(op), .data(wdata), .mask(bmask), .q(pad_out)
  );

  pin_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_i(pad_in), .sync_o(pin_sync_q)
  );

  always_comb begin
    rd_val = '0;
    if (dir_hit)      rd_val[NPINS-1:0] = pad_oe_n;
    else if (out_hit) rd_val[NPINS-1:0] = pad_out;
    else if (pin_hit) rd_val[NPINS-1:0] = pin_sync_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= accept;
      if (accept) wb_dat_o <= rd_val;
    end
  end

endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_cyc_i,
  input logic              wb_stb_i,
  input logic              wb_we_i,
  input logic [AW-1:0]     wb_adr_i,
  input logic [DW-1:0]     wb_dat_i,
  input logic [DW/8-1:0]   wb_sel_i,
  input logic [DW-1:0]     wb_dat_o,
  input logic              wb_ack_o,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe_n
);

  logic             req_new, wr_new;
  logic [NPINS-1:0] m, dm;
  logic [AW-1:0]    a;

  assign req_new = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign wr_new  = req_new & wb_we_i;
  assign a       = wb_adr_i;

  always_comb begin
    for (int b = 0; b < NPINS; b++) m[b] = wb_sel_i[b/8];
  end
  assign dm = wb_dat_i[NPINS-1:0] & m;

  assert_ack_next_R2: assert property (@(posedge clk) disable iff (rst)
    req_new |=> wb_ack_o);
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);
  assert_dir_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_new && a == AW'(8'h00)) |=> pad_oe_n == (($past(pad_oe_n) & ~$past(m)) | $past(dm)));
  assert_out_set_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_new && a == AW'(8'h14)) |=> pad_out == ($past(pad_out) | $past(dm)));
  assert_out_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_new && a == AW'(8'h18)) |=> pad_out == ($past(pad_out) & ~$past(dm)));
  assert_dir_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_new && a == AW'(8'h0C)) |=> pad_oe_n == ($past(pad_oe_n) ^ $past(dm)));
  assert_unsel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out ^ $past(pad_out)) & ~$past(m)) == '0);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_new && a < AW'(8'h20)) |=> ($stable(pad_out) && $stable(pad_oe_n)));

endmodule

bind pin_bank_top pin_bank_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_pin_bank_top.sv
module tb_pin_bank_top;

  localparam int unsigned NP = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] wdat = '0;
  logic [3:0]    sel = '0;
  logic [DW-1:0] rdat;
  logic          ack;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pout, poe_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pin_bank_top #(.NPINS(NP), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel), .wb_dat_o(rdat),
    .wb_ack_o(ack), .pad_in(pin_i), .pad_out(pout), .pad_oe_n(poe_n)
  );

  logic [NP-1:0] m_dir = '1;
  logic [NP-1:0] m_out = '0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [NP-1:0] model(input logic [NP-1:0] old, input logic [NP-1:0] d,
                                          input logic [1:0] s, input logic [1:0] op);
    logic [NP-1:0] mk, h;
    mk = {{8{s[1]}}, {8{s[0]}}};
    h  = d & mk;
    case (op)
      2'd0: return (old & ~mk) | h;
      2'd1: return old | h;
      2'd2: return old & ~h;
      default: return old ^ h;
    endcase
  endfunction

  // One access; R2 is checked on every call.
  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s, output logic [31:0] r);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a[AW-1:0]; wdat = d; sel = s;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ack", {31'd0, ack}, 32'd1);
    r = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R2 ack pulse", {31'd0, ack}, 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] r;
    acc(1'b1, a, d, s, r);
    if (a < 8'h10)      m_dir = model(m_dir, d[NP-1:0], s[1:0], a[3:2]);
    else if (a < 8'h20) m_out = model(m_out, d[NP-1:0], s[1:0], a[3:2]);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    acc(1'b0, a, 32'd0, 4'h0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 oe_n in reset", {16'd0, poe_n}, 32'h0000_FFFF);
    chk("R1 out in reset",  {16'd0, pout},  32'd0);
    chk("R1 ack in reset",  {31'd0, ack},   32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe_n after reset", {16'd0, poe_n}, 32'h0000_FFFF);
    chk("R1 out after reset",  {16'd0, pout},  32'd0);

    // Sweep every op, group, byte select and read alias.
    for (int i = 0; i < 256; i++) begin
      logic [NP-1:0] base, d;
      logic [7:0] grp;
      base = {i[7:0], ~i[7:0]} ^ 16'h3C5A;
      d    = NP'((i * 16'h9E37) ^ 16'h0F0F);
      grp  = i[4] ? 8'h10 : 8'h00;
      wr(grp, {16'hDEAD, base}, 4'hF);
      wr(grp | {4'd0, i[3:2], 2'b00}, {16'hBEEF, d}, i[3:0] & 4'h3);
      rd(grp | {4'd0, i[7:6], 2'b00}, r);
      if (i[4]) chk("R3 R4 R5 R6 R7 R8 out read", r, {16'd0, m_out});
      else      chk("R3 R4 R5 R6 R7 R8 dir read", r, {16'd0, m_dir});
      chk("R11 pad_out", {16'd0, pout},  {16'd0, m_out});
      chk("R11 pad_oe_n", {16'd0, poe_n}, {16'd0, m_dir});
    end

    // R12: bitwise build-up equals one plain write; toggle of all-ones field clears it.
    wr(8'h10, 32'h0000_0001, 4'h3);
    for (int b = 12; b < 16; b++) wr(8'h14, 32'd1 << b, 4'h3);
    rd(8'h10, r);
    chk("R12 set one at a time", r, 32'h0000_F001);
    wr(8'h1C, 32'h0000_F000, 4'h3);
    rd(8'h14, r);
    chk("R12 toggle all-ones field", r, 32'h0000_0001);
    for (int b = 12; b < 16; b++) wr(8'h18, 32'd1 << b, 4'h3);
    rd(8'h18, r);
    chk("R5 clear one at a time", r, 32'h0000_0001);

    // R10: input and unmapped offsets.
    wr(8'h00, 32'h0000_1234, 4'h3);
    wr(8'h20, 32'hFFFF_FFFF, 4'hF);
    wr(8'h24, 32'hFFFF_FFFF, 4'hF);
    wr(8'h3C, 32'h0000_0000, 4'hF);
    rd(8'h0C, r);
    chk("R10 dir kept", r, 32'h0000_1234);
    rd(8'h1C, r);
    chk("R10 out kept", r, {16'd0, m_out});
    rd(8'h24, r);
    chk("R10 unmapped read", r, 32'd0);
    rd(8'h3C, r);
    chk("R10 unmapped read high", r, 32'd0);

    // R9: synchronised inputs.
    foreach (pin_i[k]) begin end
    for (int p = 0; p < 6; p++) begin
      logic [NP-1:0] v;
      v = (p == 5) ? 16'hABCD : NP'((p * 16'h1111) ^ (p & 1 ? 16'h8002 : 16'h0001));
      @(negedge clk);
      pin_i = v;
      repeat (3) @(negedge clk);
      rd(8'h20, r);
      chk("R9 pin level", r, {16'd0, v});
    end
    // Change in the request cycle is not yet visible.
    @(negedge clk);
    pin_i = 16'h5A5A;
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 6'h20; sel = 4'h0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 sync latency old value", rdat, 32'h0000_ABCD);
    cyc = 1'b0; stb = 1'b0;
    rd(8'h20, r);
    chk("R9 sync new value", r, 32'h0000_5A5A);

    // R1 again: reset mid-run restores defaults.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 re-reset oe_n", {16'd0, poe_n}, 32'h0000_FFFF);
    chk("R1 re-reset out",  {16'd0, pout},  32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule